// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Unit

This block generates the interrupts for a synchronous serial port that has an 8-entry transmit FIFO and an 8-entry receive FIFO of 16-bit half-words. It never touches FIFO storage. It sees only the two fill levels and a receive push strobe. From these it derives three raw sources:

- a transmit service request, driven while at least half of the transmit FIFO is free;
- a receive service request, driven while at least half of the receive FIFO is filled;
- a sticky receive-overrun flag, set when a word arrives at a full receive FIFO.

Software uses three registers on a small synchronous bus with address, write enable, write data and read data. A control register holds one enable bit per source. A status register shows the raw sources. Any write to a clear register drops the overrun flag. Writing the control register with the overrun enable at zero also drops the flag. The three enabled sources are ORed and registered to form a single interrupt line.

Top module: `sport_irq_top`

## Requirements
- R1: While `rst_ni` is low, `rx_ovr_o`, `irq_o`, `bus_rdata_o` and all enable bits are zero.
- R2: `tx_req_o` is high in the same cycle whenever the free space in the transmit FIFO is at least `DEPTH/2`. With `DEPTH`=8 this means `tx_level_i` <= 4. Otherwise it is low.
- R3: `rx_req_o` is high in the same cycle whenever `rx_level_i` >= `DEPTH/2` (4). Otherwise it is low.
- R4: A cycle with `rx_push_i` high while `rx_level_i` equals `DEPTH` sets `rx_ovr_o` after that clock edge. The flag then stays high until one of the two clears in R5 or R6.
- R5: A write of any data to address 2 clears `rx_ovr_o` after that clock edge.
- R6: A write to address 0 with data bit 2 at zero clears `rx_ovr_o` after that clock edge.
- R7: When a set condition (R4) and a clear (R5 or R6) occur in the same cycle, the set wins and `rx_ovr_o` is high after the edge.
- R8: A read of address 1 returns the status one cycle later on `bus_rdata_o`. The value is the status as it stood at the sampling edge: bit 0 is the receive request, bit 1 is the transmit request, bit 2 is the overrun flag, and the higher bits are zero. Address 3 reads as zero.
- R9: Address 0 is the control register. Its bit 0 enables the receive request, bit 1 the transmit request and bit 2 the overrun. It reads back with the same one-cycle latency, with its higher bits zero.
- R10: `irq_o` equals, one cycle later, the OR of the three sources each ANDed with its enable bit. A source whose enable bit is zero does not raise `irq_o`.
- R11: Writes to address 2 do not change `tx_req_o` or `rx_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_level_i | input | CNT_W (4) | Transmit FIFO fill level |
| rx_level_i | input | CNT_W (4) | Receive FIFO fill level |
| rx_push_i | input | 1 | A word arrives at the receive FIFO |
| bus_addr_i | input | ADDR_W (2) | Register address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | DATA_W (16) | Write data |
| bus_rdata_o | output | DATA_W (16) | Read data, one cycle after the address |
| tx_req_o | output | 1 | Raw transmit service request |
| rx_req_o | output | 1 | Raw receive service request |
| rx_ovr_o | output | 1 | Sticky receive overrun flag |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The two service requests are combinational, so they are checked in the same half-cycle in which the new levels are driven. The overrun flag is due after one rising edge, and so are the effects of a clear write or a control write. `irq_o` and `bus_rdata_o` are each one register behind their sources, so they are sampled on the falling edge one full cycle after the stimulus. The scoreboard only pops an expected read value on the falling edge that follows the rising edge at which the address was sampled.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;
  localparam int unsigned SRC_RX  = 0;
  localparam int unsigned SRC_TX  = 1;
  localparam int unsigned SRC_OVR = 2;
  localparam int unsigned NSRC    = 3;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_CLR  = 2'd2,
    REG_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sport_irq_level.sv
module sport_irq_level #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] tx_level_i,
  input  logic [CNT_W-1:0] rx_level_i,
  output logic             tx_req_o,
  output logic             rx_req_o
);
  localparam int unsigned HALF = DEPTH / 2;
  localparam logic [CNT_W:0] HALF_W  = (CNT_W+1)'(HALF);
  localparam logic [CNT_W:0] DEPTH_W = (CNT_W+1)'(DEPTH);

  logic [CNT_W:0] tx_free;

  always_comb begin
    tx_free  = DEPTH_W - {1'b0, tx_level_i};
    tx_req_o = (tx_free >= HALF_W);
    rx_req_o = ({1'b0, rx_level_i} >= HALF_W);
  end
endmodule

// File: rtl/sport_irq_ovr.sv
module sport_irq_ovr #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic             clr_i,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic set;
  assign set = push_i && (level_i == FULL);

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_ovr_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && level_i == FULL) |=> flag_o);
  p_ovr_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  p_ovr_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(push_i && level_i == FULL)) |=> !flag_o);
  p_ovr_win_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && push_i && level_i == FULL) |=> flag_o);
endmodule

// File: rtl/sport_irq_regs.sv
module sport_irq_regs
  import sport_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   status_i,
  output logic [NSRC-1:0]   en_o,
  output logic              ovr_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic ctrl_wr, clr_wr;
  logic [DATA_W-1:0] rd_next;

  assign ctrl_wr   = we_i && (addr_i == ADDR_W'(REG_CTRL));
  assign clr_wr    = we_i && (addr_i == ADDR_W'(REG_CLR));
  assign ovr_clr_o = clr_wr || (ctrl_wr && !wdata_i[SRC_OVR]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (ctrl_wr) en_o <= wdata_i[NSRC-1:0];
  end

  always_comb begin
    rd_next = '0;
    unique case (addr_i)
      ADDR_W'(REG_CTRL): rd_next[NSRC-1:0] = en_o;
      ADDR_W'(REG_STAT): rd_next[NSRC-1:0] = status_i;
      default:           rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_next;
  end

  p_stat_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(REG_STAT)) |=> (rdata_o == DATA_W'($past(status_i))));
  p_en_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(en_o));
endmodule

// File: rtl/sport_irq_top.sv
module sport_irq_top
  import sport_irq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1),
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  tx_level_i,
  input  logic [CNT_W-1:0]  rx_level_i,
  input  logic              rx_push_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              tx_req_o,
  output logic              rx_req_o,
  output logic              rx_ovr_o,
  output logic              irq_o
);
  logic [NSRC-1:0] src, en;
  logic ovr_clr, irq_q;

  sport_irq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .tx_level_i(tx_level_i),
    .rx_level_i(rx_level_i),
    .tx_req_o  (tx_req_o),
    .rx_req_o  (rx_req_o)
  );

  sport_irq_ovr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rx_push_i),
    .level_i(rx_level_i),
    .clr_i  (ovr_clr),
    .flag_o (rx_ovr_o)
  );

  always_comb begin
    src          = '0;
    src[SRC_RX]  = rx_req_o;
    src[SRC_TX]  = tx_req_o;
    src[SRC_OVR] = rx_ovr_o;
  end

  sport_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .wdata_i  (bus_wdata_i),
    .status_i (src),
    .en_o     (en),
    .ovr_clr_o(ovr_clr),
    .rdata_o  (bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(src & en);
  end
  assign irq_o = irq_q;

  p_irq_lat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(src & en)));
  p_irq_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |=> !irq_o);
endmodule

// File: tb/sport_irq_top_bench.sv
`timescale 1ns/1ps
module sport_irq_top_bench;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] tx_lvl = '0, rx_lvl = '0;
  logic push = 1'b0, we = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic tx_req, rx_req, ovr, irq;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [15:0] val; string req; } exp_t;
  exp_t exp_q[$];
  logic rd_pend = 1'b0;

  always #4 clk = ~clk;

  sport_irq_top u_sport_irq_top (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_level_i(tx_lvl), .rx_level_i(rx_lvl), .rx_push_i(push),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .tx_req_o(tx_req), .rx_req_o(rx_req),
    .rx_ovr_o(ovr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: a read issued before a rising edge is compared on the next falling edge
  always @(posedge clk) rd_pend <= rd;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.req, rdata, e.val);
    end
  end

  task automatic step();
    @(negedge clk);
    we = 1'b0; rd = 1'b0; push = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d; rd = 1'b0; push = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [15:0] e, input string req);
    exp_t it;
    @(negedge clk);
    addr = a; we = 1'b0; rd = 1'b1; push = 1'b0;
    it.val = e; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic levels(input int t, input int r);
    @(negedge clk);
    we = 1'b0; rd = 1'b0; push = 1'b0;
    tx_lvl = CNT_W'(t); rx_lvl = CNT_W'(r);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq", 16'(irq), 16'd0);
    chk("R1 ovr", 16'(ovr), 16'd0);
    chk("R1 rdata", rdata, 16'd0);
    rst_n = 1'b1;
    rd_exp(2'd0, 16'h0000, "R1 enables");

    // R2 / R3 thresholds
    levels(0, 0);  chk("R2 tx lvl0", 16'(tx_req), 16'd1); chk("R3 rx lvl0", 16'(rx_req), 16'd0);
    levels(4, 3);  chk("R2 tx lvl4", 16'(tx_req), 16'd1); chk("R3 rx lvl3", 16'(rx_req), 16'd0);
    levels(5, 4);  chk("R2 tx lvl5", 16'(tx_req), 16'd0); chk("R3 rx lvl4", 16'(rx_req), 16'd1);
    levels(8, 8);  chk("R2 tx lvl8", 16'(tx_req), 16'd0); chk("R3 rx lvl8", 16'(rx_req), 16'd1);

    // R8 status readback: rx=1 tx=0 ovr=0
    levels(5, 4);
    rd_exp(2'd1, 16'h0001, "R8 status");
    rd_exp(2'd3, 16'h0000, "R8 unmapped");

    // R9 control
    wr(2'd0, 16'hFFFF);
    rd_exp(2'd0, 16'h0007, "R9 ctrl");

    // R10 latency
    levels(8, 0);
    step(); step();
    chk("R10 idle", 16'(irq), 16'd0);
    levels(8, 4);
    chk("R10 before edge", 16'(irq), 16'd0);
    step();
    chk("R10 after edge", 16'(irq), 16'd1);

    // R4 overrun set and hold
    levels(8, 8);
    push = 1'b1;
    step();
    chk("R4 set", 16'(ovr), 16'd1);
    step(); step();
    chk("R4 sticky", 16'(ovr), 16'd1);
    rd_exp(2'd1, 16'h0005, "R8 status ovr");

    // R5 clear, R11 levels unaffected
    wr(2'd2, 16'h1234);
    chk("R11 rx", 16'(rx_req), 16'd1);
    chk("R11 tx", 16'(tx_req), 16'd0);
    step();
    chk("R5 clear", 16'(ovr), 16'd0);

    // R7 set wins over clear
    wr(2'd2, 16'h0000);
    push = 1'b1;
    step();
    chk("R7 priority", 16'(ovr), 16'd1);

    // R6 enable drop clears
    wr(2'd0, 16'h0003);
    step();
    chk("R6 enable clear", 16'(ovr), 16'd0);
    rd_exp(2'd0, 16'h0003, "R9 ctrl 3");

    // R10 masked overrun
    levels(8, 8);
    push = 1'b1;
    step();
    chk("R4 set masked", 16'(ovr), 16'd1);
    levels(8, 0);
    step();
    chk("R10 masked ovr", 16'(irq), 16'd0);

    // R7 with control write
    levels(8, 8);
    addr = 2'd0; we = 1'b1; wdata = 16'h0000; push = 1'b1;
    step();
    chk("R7 ctrl priority", 16'(ovr), 16'd1);

    repeat (4) step();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule